// File: doc/BRIEF.md
# Character Display Message Sequencer

This block is the client state machine that sits in front of a character display's bus transaction engine. After reset it sends a fixed set of setup instructions to the display, then writes a parameterized text string one byte at a time. Once the text is written it stops and stays quiet.

Each byte is one step made of two states: an issue state and a wait state. In the issue state the block presents the byte and the register-select value and raises `wr_begin` for one clock. In the wait state it holds the byte until the engine reports `wr_done`. Instruction steps drive register-select low and character steps drive it high. The pin-level bus timing and any read-back from the display belong to the engine, not to this block.

The text is held in a packed parameter of up to `MSG_MAX` bytes. Character k sits in bits [8k+7:8k], and only the first `MSG_LEN` characters are sent. A step counter picks out the current byte, so the block needs no separate state for each letter.

Top module: `lcd_msg_seq`

## Requirements
- R1: While `rst_n` is low, `wr_begin` stays low. The reset is asynchronous and active low; its release is synchronized to `clk`.
- R2: The first four steps after reset are instruction writes with `wr_rs` = 0, in this order: 0x38 (8-bit bus, two lines), 0x0C (display on, cursor off), 0x01 (clear), 0x06 (increment address, no shift).
- R3: After the instructions come `MSG_LEN` character writes with `wr_rs` = 1, taken in order from character 0 upward. Character k is `MSG[8k+7:8k]` in ASCII, so a letter D is sent as 0x44.
- R4: Each step raises `wr_begin` for exactly one clock. Every byte is requested exactly once.
- R5: After a begin pulse, `wr_byte` and `wr_rs` stay stable and no new begin is raised until `wr_done` is seen high in the wait state.
- R6: A `wr_done` that is high during the issue cycle does not skip a step. If `wr_done` is held high all the time, every byte is still written once and in order.
- R7: After the last character the block enters a terminal idle state. From then on it raises no `wr_begin`, whatever `wr_done` does, until the next reset.
- R8: A reset applied in the middle of the sequence restarts the sequence from the first instruction (0x38).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock (the slow state-machine clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_done | input | 1 | From the bus engine: the requested write has finished |
| wr_begin | output | 1 | One-clock request to start a write |
| wr_rs | output | 1 | Register select: 0 = instruction, 1 = character data |
| wr_byte | output | 8 | Byte to be written |

## Verification
The hardest situations to reach from the ports come from how `wr_done` is timed against the issue/wait pairing. They are: `wr_done` already high while a byte is being issued, `wr_done` noise after the sequence has ended, and a reset that lands part way through the sequence. The bench has a bus-engine model that answers each begin after a random delay of one to four clocks. In a second mode it holds `wr_done` permanently high, and after the last character it drives random `wr_done` pulses. In one run it also pulls reset after the sixth write. Every observed write is compared with an expected list that the bench builds from the instruction table and a 16-character message, which is the longest message the block allows.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int INIT_N = 4;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_IDLE  = 2'd3
  } seq_state_t;

  // Setup instruction list, sent in this order after reset.
  function automatic logic [7:0] init_cmd(input logic [1:0] pos);
    case (pos)
      2'd0:    init_cmd = 8'h38;  // 8-bit bus, two lines
      2'd1:    init_cmd = 8'h0C;  // display on, cursor off
      2'd2:    init_cmd = 8'h01;  // clear
      default: init_cmd = 8'h06;  // increment, no shift
    endcase
  endfunction

endpackage

// File: rtl/lcdseq_rst_sync.sv
module lcdseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];

endmodule

// File: rtl/lcdseq_step_rom.sv
module lcdseq_step_rom
  import lcdseq_pkg::*;
#(
  parameter int MSG_MAX = 16,
  parameter int IDX_W   = 5,
  parameter logic [8*MSG_MAX-1:0] MSG = '0
) (
  input  logic [IDX_W-1:0] step_idx,
  output logic [7:0]       step_byte,
  output logic             step_rs
);

  always_comb begin
    step_byte = 8'h00;
    step_rs   = 1'b0;
    if (step_idx < IDX_W'(INIT_N)) begin
      step_byte = init_cmd(step_idx[1:0]);
    end else begin
      step_rs = 1'b1;
      for (int k = 0; k < MSG_MAX; k++) begin
        if (step_idx == IDX_W'(INIT_N + k)) step_byte = MSG[8*k +: 8];
      end
    end
  end

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int LAST_IDX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_done,
  output logic [IDX_W-1:0] step_idx,
  output logic             issue,
  output logic             waiting,
  output logic             idle
);

  seq_state_t state, state_nxt;
  logic       idx_adv;
  logic       at_last;

  assign at_last = (step_idx == IDX_W'(LAST_IDX));

  always_comb begin
    state_nxt = state;
    idx_adv   = 1'b0;
    case (state)
      ST_RESET: state_nxt = ST_ISSUE;
      ST_ISSUE: state_nxt = ST_WAIT;
      ST_WAIT: begin
        if (wr_done) begin
          if (at_last) begin
            state_nxt = ST_IDLE;
          end else begin
            state_nxt = ST_ISSUE;
            idx_adv   = 1'b1;
          end
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RESET;
      step_idx <= '0;
    end else begin
      state <= state_nxt;
      if (idx_adv) step_idx <= step_idx + 1'b1;
    end
  end

  assign issue   = (state == ST_ISSUE);
  assign waiting = (state == ST_WAIT);
  assign idle    = (state == ST_IDLE);

endmodule

// File: rtl/lcd_msg_seq.sv
module lcd_msg_seq
  import lcdseq_pkg::*;
#(
  parameter int MSG_MAX = 16,
  parameter int MSG_LEN = 4,
  parameter logic [8*MSG_MAX-1:0] MSG = {{(8*MSG_MAX-32){1'b0}}, 32'h656E_6F44},
  localparam int STEPS = INIT_N + MSG_LEN,
  localparam int IDX_W = $clog2(INIT_N + MSG_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_done,
  output logic       wr_begin,
  output logic       wr_rs,
  output logic [7:0] wr_byte
);

  logic             rst_sync_n;
  logic [IDX_W-1:0] step_idx;
  logic             seq_issue;
  logic             seq_waiting;
  logic             seq_idle;

  lcdseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcdseq_ctrl #(.IDX_W(IDX_W), .LAST_IDX(STEPS - 1)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_done  (wr_done),
    .step_idx (step_idx),
    .issue    (seq_issue),
    .waiting  (seq_waiting),
    .idle     (seq_idle)
  );

  lcdseq_step_rom #(.MSG_MAX(MSG_MAX), .IDX_W(IDX_W), .MSG(MSG)) u_rom (
    .step_idx  (step_idx),
    .step_byte (wr_byte),
    .step_rs   (wr_rs)
  );

  assign wr_begin = seq_issue;

endmodule

// File: rtl/lcd_msg_seq_chk.sv
module lcd_msg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_begin,
  input logic       wr_done,
  input logic       wr_rs,
  input logic [7:0] wr_byte,
  input logic       waiting,
  input logic       idle
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !wr_begin);

  // R2
  init_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_begin && !wr_rs) |-> (wr_byte == 8'h38 || wr_byte == 8'h0C ||
                              wr_byte == 8'h01 || wr_byte == 8'h06));

  // R4
  begin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_begin |=> !wr_begin);

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !wr_done) |=> ($stable(wr_byte) && $stable(wr_rs) && !wr_begin));

  // R7
  idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (idle && !wr_begin));

endmodule

bind lcd_msg_seq lcd_msg_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_begin (wr_begin),
  .wr_done  (wr_done),
  .wr_rs    (wr_rs),
  .wr_byte  (wr_byte),
  .waiting  (seq_waiting),
  .idle     (seq_idle)
);

// File: tb/tb_lcd_msg_seq.sv
module tb_lcd_msg_seq;

  localparam int MAXC  = 16;
  localparam int LEN   = 16;
  localparam int TOTAL = 4 + LEN;
  localparam logic [127:0] TXT = "Display D ready!";

  function automatic logic [127:0] pack_msg(input logic [127:0] s);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = s[127-8*i -: 8];
    return r;
  endfunction

  localparam logic [127:0] MSGV = pack_msg(TXT);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_done = 1'b0;
  logic       wr_begin, wr_rs;
  logic [7:0] wr_byte;

  lcd_msg_seq #(.MSG_MAX(MAXC), .MSG_LEN(LEN), .MSG(MSGV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done),
    .wr_begin(wr_begin), .wr_rs(wr_rs), .wr_byte(wr_byte)
  );

  always #4 clk = ~clk;

  int   checks = 0, fails = 0;
  int   exp_idx = 0, cd = 0;
  bit   hold_mode = 0, noise_mode = 0, prev_begin = 0, after_reset = 0, ended = 0;
  logic [7:0] held_b = 8'h00;
  logic       held_rs = 1'b0;

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return 8'h38;
      1: return 8'h0C;
      2: return 8'h01;
      3: return 8'h06;
      default: return MSGV[8*(i-4) +: 8];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Bus-engine model and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!wr_begin, "R1", "begin during reset", wr_begin, 0);
      exp_idx = 0; cd = 0; after_reset = 1; prev_begin = 0;
      wr_done = hold_mode;
    end else begin
      if (cd > 0)
        chk(!wr_begin && wr_byte == held_b && wr_rs == held_rs, "R5",
            "byte not held while waiting", {wr_begin, wr_rs, wr_byte}, {1'b0, held_rs, held_b});
      if (hold_mode)                      wr_done = 1'b1;
      else if (noise_mode && cd == 0)     wr_done = 1'($urandom % 2);
      else                                wr_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) wr_done = 1'b1;
      end
      if (wr_begin) begin
        chk(!prev_begin, "R4", "begin wider than one clock", 1, 0);
        if (exp_idx >= TOTAL) begin
          chk(0, "R7", "write after last character", wr_byte, 0);
        end else begin
          chk(wr_byte == exp_byte(exp_idx) && wr_rs == (exp_idx >= 4),
              (exp_idx < 4) ? "R2" : (hold_mode ? "R6" : "R3"),
              $sformatf("step %0d byte/rs", exp_idx),
              {wr_rs, wr_byte}, {(exp_idx >= 4), exp_byte(exp_idx)});
          if (after_reset) chk(wr_byte == 8'h38, "R8", "first write after reset", wr_byte, 8'h38);
          after_reset = 0;
          exp_idx++;
        end
        held_b = wr_byte; held_rs = wr_rs;
        if (!hold_mode) cd = 1 + int'($urandom % 4);
      end
      prev_begin = wr_begin;
    end
  end

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R7", "watchdog expired", exp_idx, TOTAL);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    // Run 1: random done delays, then done noise after the end
    do_reset();
    wait (exp_idx == TOTAL);
    chk(MSGV[7:0] == 8'h44, "R3", "letter D code", MSGV[7:0], 8'h44);
    #1 noise_mode = 1;
    repeat (60) @(negedge clk);
    #1 noise_mode = 0;
    chk(exp_idx == TOTAL, "R7", "write count after noise", exp_idx, TOTAL);
    // Run 2: reset mid-sequence, then done held high
    do_reset();
    wait (exp_idx == 6);
    #1 hold_mode = 1;
    do_reset();
    wait (exp_idx == TOTAL);
    repeat (30) @(negedge clk);
    chk(exp_idx == TOTAL, "R6", "write count with done held", exp_idx, TOTAL);
    #1 hold_mode = 0;
    // Run 3: random delays again
    do_reset();
    wait (exp_idx == TOTAL);
    repeat (30) @(negedge clk);
    chk(exp_idx == TOTAL, "R7", "final write count", exp_idx, TOTAL);
    finish_run();
  end

endmodule